// File: doc/BRIEF.md
# Rotating Trace-Forward Survivor Unit

This block is the survivor-path stage of a Viterbi decoder. Each valid cycle it takes one decision vector from the add-compare-select stage. The vector holds one bit per trellis state. From these vectors the block returns the decoded bit stream. It does not use a register-exchange array, where every register switches on every step. Instead it keeps `L/M` banks of trace-forward registers. Each bank has one `M`-bit state label per trellis state. Only one bank is written at a time. A bank stays active for `M` valid inputs, and then the duty moves on to the next bank in circular order.

In the last cycle of each window, a purely combinational chain of `N`-to-1 selectors starts from state 0. It walks back through the bank being written and then through the frozen banks, from newest to oldest. The label it reads from the oldest bank is a reliable encoder state. The bits of that state are the last `M` encoder inputs, so they give `M` decoded bits. These bits leave the block serially on the following cycles, oldest first. `M` must be at least 2, and `L` must be a multiple of `M`.

Top module: `tf_survivor`

## Requirements
- R1: The block holds `L/M` banks. On a valid cycle exactly one bank is written, and every other bank keeps its contents.
- R2: The active bank stays active for `M` valid inputs and then hands over to the next bank index, wrapping from the last bank to bank 0.
- R3: A traceback happens once per window, on its `M`-th valid input, and only after warm-up. Its result equals the state reached by starting at state 0 and stepping back through the last `L` decision vectors.
- R4: Predecessor rule: state `n` with decision bit `d` (bit `n` of the vector) comes from state `{d, n[M-1:1]}`, so the decision bit becomes the MSB of the earlier state.
- R5: The bits of a traced state are emitted MSB first, which is oldest input first. With error-free decisions, the output stream equals the encoder input stream, in order.
- R6: `bit_valid` stays low until `L/M` full windows have completed after reset. The first decoded bit appears on the cycle after the `(L+M)`-th valid input, and it carries encoder input 0.
- R7: A cycle with `in_valid` low has no effect. Its decision vector is ignored, and no bank, window position or bank index changes.
- R8: Each traceback yields exactly `M` consecutive cycles with `bit_valid` high, one decoded bit per cycle, and these bursts never overlap.
- R9: An active-low asynchronous reset clears `bit_valid` and restarts warm-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Decision vector present this cycle |
| in_dec | input | 2**M | One survivor decision bit per state |
| bit_valid | output | 1 | Decoded bit present |
| bit_out | output | 1 | Decoded bit, oldest first |

## Verification
The first pattern drives error-free decisions from a random input sequence. All survivors then merge, so the output must reproduce the input bits in order. This separates a correct bit order and delay from a reversed or shifted one. The second pattern drives fully random decision vectors with random idle gaps. Here each traced label depends on every selector step and on which bank sits at each depth, so it exposes wrong predecessor rules, wrong bank order and any leak from idle cycles. A directed warm-up count and a mid-stream reset pin down when the first bit may appear.

// File: rtl/tf_survivor.sv
module tf_survivor #(
  parameter int M = 2,
  parameter int L = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [(1<<M)-1:0] in_dec,
  output logic              bit_valid,
  output logic              bit_out
);
  localparam int N  = 1 << M;
  localparam int NB = L / M;
  localparam int AW = (NB > 1) ? $clog2(NB) : 1;
  localparam int PW = (M > 1) ? $clog2(M) : 1;
  localparam int WW = $clog2(NB + 1);

  function automatic logic [M-1:0] pred(input logic [M-1:0] s, input logic d);
    return {d, s[M-1:1]};
  endfunction

  logic [NB-1:0][N-1:0][M-1:0] bank;
  logic [N-1:0][M-1:0]         nxt;
  logic [NB-1:0][M-1:0]        chain;
  logic [NB-1:0]               en;
  logic [AW-1:0]               act;
  logic [PW-1:0]               phase, left;
  logic [WW-1:0]               wins;
  logic [M-1:0]                shreg, tb_state;
  logic                        last, fire;

  assign last = (phase == PW'(M-1));
  assign fire = in_valid && last && (wins == WW'(NB));

  always_comb
    for (int n = 0; n < N; n++)
      nxt[n] = (phase == '0) ? pred(M'(n), in_dec[n])
                             : bank[act][pred(M'(n), in_dec[n])];

  assign chain[0] = nxt[0];
  for (genvar k = 1; k < NB; k++) begin : g_tb
    assign chain[k] = bank[AW'((int'(act) + NB - k) % NB)][chain[k-1]];
  end
  assign tb_state = chain[NB-1];

  for (genvar b = 0; b < NB; b++) begin : g_en
    assign en[b] = in_valid && (act == AW'(b));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bank <= '0;
    else
      for (int b = 0; b < NB; b++)
        if (en[b]) bank[b] <= nxt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= '0;
      act   <= '0;
      wins  <= '0;
    end else if (in_valid) begin
      if (last) begin
        phase <= '0;
        act   <= (act == AW'(NB-1)) ? '0 : act + 1'b1;
        if (wins != WW'(NB)) wins <= wins + 1'b1;
      end else begin
        phase <= phase + 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
      shreg     <= '0;
      left      <= '0;
    end else if (fire) begin
      bit_valid <= 1'b1;
      bit_out   <= tb_state[M-1];
      shreg     <= tb_state << 1;
      left      <= PW'(M-1);
    end else if (left != '0) begin
      bit_valid <= 1'b1;
      bit_out   <= shreg[M-1];
      shreg     <= shreg << 1;
      left      <= left - 1'b1;
    end else begin
      bit_valid <= 1'b0;
    end
endmodule

// File: rtl/tf_survivor_chk.sv
module tf_survivor_chk #(
  parameter int M = 2,
  parameter int L = 8
) (
  input logic                                     clk,
  input logic                                     rst_n,
  input logic                                     in_valid,
  input logic                                     bit_valid,
  input logic                                     fire,
  input logic [L/M-1:0]                           en,
  input logic [((L/M > 1) ? $clog2(L/M) : 1)-1:0] act,
  input logic [((M > 1) ? $clog2(M) : 1)-1:0]     phase,
  input logic [((M > 1) ? $clog2(M) : 1)-1:0]     left,
  input logic [L/M-1:0][(1<<M)-1:0][M-1:0]        bank
);
  localparam int NB = L / M;
  logic [15:0] vcnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) vcnt <= '0;
    else if (in_valid && vcnt != 16'hFFFF) vcnt <= vcnt + 1'b1;

  a_r1_one_bank: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(en));

  for (genvar b = 0; b < NB; b++) begin : g_hold
    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en[b] |=> $stable(bank[b]));
  end

  a_r2_stay: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phase != M-1) |=> $stable(act));
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && phase == M-1 && act == NB-1) |=> act == 0);
  a_r6_warmup: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |-> vcnt >= 16'(L + M));
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(phase) && $stable(act) && $stable(bank)));
  a_r8_burst: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> bit_valid);
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> left == 0);
endmodule

bind tf_survivor tf_survivor_chk #(.M(M), .L(L)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .bit_valid(bit_valid),
  .fire(fire), .en(en), .act(act), .phase(phase), .left(left), .bank(bank)
);

// File: tb/sim_tf_survivor.sv
`timescale 1ns/1ps
module sim_tf_survivor;
  localparam int M = 2;
  localparam int L = 8;
  localparam int N = 1 << M;
  localparam int MAXT = 4096;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
  logic [N-1:0] in_dec = '0;
  logic bit_valid, bit_out;

  tf_survivor #(.M(M), .L(L)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dec(in_dec),
    .bit_valid(bit_valid), .bit_out(bit_out)
  );

  always #10 clk = ~clk;

  int total = 0, fails = 0, tcount = 0, seen = 0, run = 0;
  bit clean = 1'b0, mon_on = 1'b0, done = 1'b0;
  string tag = "R5";
  logic [N-1:0] dh [MAXT];
  bit uarr [MAXT];
  bit exp_q[$];

  task automatic check(string req, int got, int exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic logic [M-1:0] ref_trace(int t);
    logic [M-1:0] s = '0;
    for (int k = 0; k < L; k++) s = {dh[t-k][s], s[M-1:1]};
    return s;
  endfunction

  task automatic step(bit v, logic [N-1:0] d);
    @(negedge clk);
    in_valid = v;
    in_dec   = d;
    if (v) begin
      dh[tcount] = d;
      if (tcount % M == M-1 && tcount >= L+M-1) begin
        if (clean) begin
          for (int j = M-1; j >= 0; j--) exp_q.push_back(uarr[tcount-L-j]);
        end else begin
          logic [M-1:0] st = ref_trace(tcount);
          for (int j = M-1; j >= 0; j--) exp_q.push_back(st[j]);
        end
      end
      tcount++;
    end
  endtask

  task automatic feed_clean();
    logic [N-1:0] d;
    uarr[tcount] = 1'($urandom % 2);
    d = (tcount >= M && uarr[tcount-M]) ? '1 : '0;
    step(1'b1, d);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, N'($urandom));
  endtask

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      if (bit_valid) begin
        run++;
        seen++;
        if (exp_q.size() == 0) check({tag, " R6 unexpected bit"}, 1, 0);
        else check(tag, int'(bit_out), int'(exp_q.pop_front()));
      end else if (run != 0) begin
        check("R8 burst length", run % M, 0);
        run = 0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1 check("R9 reset bit_valid", int'(bit_valid), 0);
    @(negedge clk) rst_n = 1'b1;
    mon_on = 1'b1;

    // R5 / R6: error-free decisions, warm-up boundary
    clean = 1'b1; tag = "R5 clean stream";
    for (int i = 0; i < L+M-1; i++) feed_clean();
    step(1'b0, '0);
    #1 check("R6 no output before warm-up", seen + int'(bit_valid), 0);
    feed_clean();
    step(1'b0, '0);
    #1 check("R6 first bit after L+M inputs", int'(bit_valid), 1);
    for (int i = 0; i < 200; i++) feed_clean();
    idle(6);

    // R3 / R4 / R7: random decisions with idle gaps
    clean = 1'b0; tag = "R3 R4 R7 random";
    for (int i = 0; i < 2000; i++) begin
      if ($urandom % 10 < 3) step(1'b0, N'($urandom));
      else step(1'b1, N'($urandom));
    end
    idle(6);
    check("R8 all bits delivered", exp_q.size(), 0);

    // R9: reset mid-stream restarts warm-up
    tag = "R9 after reset";
    for (int i = 0; i < 5; i++) step(1'b1, N'($urandom));
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    exp_q.delete(); tcount = 0; run = 0;
    #1 check("R9 reset clears output", int'(bit_valid), 0);
    @(negedge clk) rst_n = 1'b1;
    seen = 0;
    for (int i = 0; i < L+M-1; i++) step(1'b1, N'($urandom));
    step(1'b0, '0);
    #1 check("R9 warm-up restarted", seen + int'(bit_valid), 0);
    for (int i = 0; i < 300; i++) step(1'b1, N'($urandom));
    idle(6);
    check("R8 all bits delivered after reset", exp_q.size(), 0);
    check("R1 R2 bits produced", int'(seen > 0), 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule